// File: doc/BRIEF.md
# PHY Management Register Bank

This block is the register bank that sits behind the serial management slave of an Ethernet PHY. The slave decodes a frame and presents a plain register access port: a 5-bit register address, a read strobe, a write strobe and 16-bit write data. Read data comes back one clock later and stays put until the next read. The bank holds a control word, a status word, two fixed identifier words and a word with a page-received flag.

What sets it apart from an ordinary register array are the side effects of access. The link bit in the status word latches low when the link drops and recovers only after software has read it. The jabber bit is sticky and clears on read. Two command bits in the control word clear themselves. One starts a software reset pulse with a length set in clock cycles. The other emits a single-cycle auto-negotiation restart pulse.

During the software reset pulse the writable control bits are held at their defaults. The event-tracking state is cleared as well. Hardware events reach the bank as level or pulse inputs, sampled on the clock.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After synchronous reset, rd_data is 16'h0000 and soft_rst_o, an_restart_o and power_down_o are all 0.
- R2: Status word (address 1) bit 2 reads 1 only while link_pass is high and no drop has been latched. Once link_pass goes low after the bit was 1, the bit reads 0, even if link_pass returns high, until the status word is read. A read returns the value held before that read's own update.
- R3: After a status read, bit 2 reads 1 again as soon as link_pass is high. This holds whether the link was already back at the read or comes back later.
- R4: Status bit 1 is set by a jabber_evt pulse and reads 0 after the status word has been read. A jabber_evt arriving in the same cycle as the read is kept for the next read.
- R5: Status bit 0 always reads 1. Status bits 15..3 read 0, and writes to address 1 have no effect.
- R6: Address 2 reads parameter ID_HI (default 16'h0000) and address 3 reads ID_LO (default 16'h8201). Writes to either are ignored.
- R7: Writing a 1 to control (address 0) bit 15 raises soft_rst_o from the cycle after the write for exactly RST_CYCLES cycles (default 50, 1 us at 50 MHz). Control bit 15 reads 1 while the pulse runs and 0 afterwards. Writing 0 there starts nothing.
- R8: While soft_rst_o is high, power_down_o is 0 and writes to the control word are ignored. The jabber, link-latch and page-received state is cleared.
- R9: Writing a 1 to control bit 9 outside a reset gives an_restart_o high for exactly one cycle, the cycle after the write. Bit 9 always reads 0.
- R10: Control bit 11 is a read/write bit that drives power_down_o. The other control bits, apart from 15, read 0.
- R11: Address 6 bit 1 is set by page_rx_evt and is cleared by link_lost, which wins when both arrive in the same cycle. Reading the word does not clear it, and its other bits read 0.
- R12: Addresses other than 0, 1, 2, 3 and 6 read 16'h0000, and writes to them are ignored.
- R13: rd_data updates only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register address |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| link_pass | input | 1 | Link state machine is in link pass |
| jabber_evt | input | 1 | Jabber condition seen |
| page_rx_evt | input | 1 | New page received and acknowledged |
| link_lost | input | 1 | Link lost, clears page flag |
| soft_rst_o | output | 1 | Software reset pulse |
| an_restart_o | output | 1 | Auto-negotiation restart pulse |
| power_down_o | output | 1 | Power-down control |

## Verification
A status read can land in the same cycle as a link drop or a jabber event. In that cycle the read-side clear and the event-side set compete for the same bit. The bench raises the event input on the same falling edge as the read strobe. It then expects the pre-event value from that read and the event's value from the next read. The same approach pits page_rx_evt against link_lost, where the flag must end up clear.

// File: rtl/phy_regs_pkg.sv
package phy_regs_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 5'd1;
  localparam logic [ADDR_W-1:0] A_IDHI = 5'd2;
  localparam logic [ADDR_W-1:0] A_IDLO = 5'd3;
  localparam logic [ADDR_W-1:0] A_PAGE = 5'd6;

  localparam int unsigned B_SRST = 15;
  localparam int unsigned B_PDN  = 11;
  localparam int unsigned B_ANRS = 9;
  localparam int unsigned B_LINK = 2;
  localparam int unsigned B_JAB  = 1;
  localparam int unsigned B_EXT  = 0;
  localparam int unsigned B_PGRX = 1;
endpackage

// File: rtl/phy_pulse_timer.sv
module phy_pulse_timer #(
  parameter int unsigned CYCLES = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (!busy && start) begin
      busy   <= 1'b1;
      remain <= CNT_W'(CYCLES - 1);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else remain <= remain - 1'b1;
    end
  end

  logic [CNT_W-1:0] chk_len;
  always_ff @(posedge clk) begin
    if (rst) chk_len <= '0;
    else if (busy) chk_len <= chk_len + 1'b1;
    else chk_len <= '0;
  end

  a_r7_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  a_r7_not_long: assert property (@(posedge clk) disable iff (rst)
    busy |-> (chk_len < CNT_W'(CYCLES)));
  a_r7_exact_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (chk_len == CNT_W'(CYCLES)));
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_regs_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              srst_busy,
  output logic              an_restart,
  output logic              power_down
);
  logic srst_start;
  assign srst_start = wr_en && wr_data[B_SRST] && !srst_busy;

  phy_pulse_timer #(.CYCLES(RST_CYCLES)) u_srst_timer (
    .clk  (clk),
    .rst  (rst),
    .start(srst_start),
    .busy (srst_busy)
  );

  always_ff @(posedge clk) begin
    if (rst || srst_busy || srst_start) power_down <= 1'b0;
    else if (wr_en) power_down <= wr_data[B_PDN];
  end

  always_ff @(posedge clk) begin
    if (rst) an_restart <= 1'b0;
    else an_restart <= wr_en && wr_data[B_ANRS] && !wr_data[B_SRST] && !srst_busy;
  end

  a_r8_pd_held: assert property (@(posedge clk) disable iff (rst)
    srst_busy |-> !power_down);
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    srst_busy |=> !an_restart);
endmodule

// File: rtl/phy_status_track.sv
module phy_status_track (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic stat_rd,
  input  logic link_pass,
  input  logic jabber_evt,
  input  logic page_rx_evt,
  input  logic link_lost,
  output logic link_ok,
  output logic jabber,
  output logic page_rx
);
  logic drop_latched;
  logic drop_next;

  always_comb begin
    if (!link_pass && link_ok) drop_next = 1'b1;
    else if (stat_rd) drop_next = 1'b0;
    else drop_next = drop_latched;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      drop_latched <= 1'b0;
      link_ok      <= 1'b0;
      jabber       <= 1'b0;
      page_rx      <= 1'b0;
    end else begin
      drop_latched <= drop_next;
      link_ok      <= link_pass && !drop_next;
      jabber       <= jabber_evt || (jabber && !stat_rd);
      page_rx      <= !link_lost && (page_rx_evt || page_rx);
    end
  end

  a_r2_down: assert property (@(posedge clk) disable iff (rst)
    !link_pass |=> !link_ok);
  a_r4_jab_set: assert property (@(posedge clk) disable iff (rst)
    (jabber_evt && !clr) |=> jabber);
  a_r11_lost: assert property (@(posedge clk) disable iff (rst)
    link_lost |=> !page_rx);
  a_r11_set: assert property (@(posedge clk) disable iff (rst)
    (page_rx_evt && !link_lost && !clr) |=> page_rx);
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_regs_pkg::*;
#(
  parameter logic [15:0] ID_HI      = 16'h0000,
  parameter logic [15:0] ID_LO      = 16'h8201,
  parameter int unsigned RST_CYCLES = 50
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  reg_addr,
  input  logic        rd_stb,
  input  logic        wr_stb,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        link_pass,
  input  logic        jabber_evt,
  input  logic        page_rx_evt,
  input  logic        link_lost,
  output logic        soft_rst_o,
  output logic        an_restart_o,
  output logic        power_down_o
);
  logic ctrl_wr, stat_rd;
  logic srst_busy, link_ok, jabber, page_rx;
  logic [DATA_W-1:0] rd_mux;

  assign ctrl_wr = wr_stb && (reg_addr == A_CTRL);
  assign stat_rd = rd_stb && (reg_addr == A_STAT);

  phy_ctrl_reg #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (ctrl_wr),
    .wr_data   (wr_data),
    .srst_busy (srst_busy),
    .an_restart(an_restart_o),
    .power_down(power_down_o)
  );

  phy_status_track u_stat (
    .clk        (clk),
    .rst        (rst),
    .clr        (srst_busy),
    .stat_rd    (stat_rd),
    .link_pass  (link_pass),
    .jabber_evt (jabber_evt),
    .page_rx_evt(page_rx_evt),
    .link_lost  (link_lost),
    .link_ok    (link_ok),
    .jabber     (jabber),
    .page_rx    (page_rx)
  );

  assign soft_rst_o = srst_busy;

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      A_CTRL: begin
        rd_mux[B_SRST] = srst_busy;
        rd_mux[B_PDN]  = power_down_o;
      end
      A_STAT: begin
        rd_mux[B_LINK] = link_ok;
        rd_mux[B_JAB]  = jabber;
        rd_mux[B_EXT]  = 1'b1;
      end
      A_IDHI:  rd_mux = ID_HI;
      A_IDLO:  rd_mux = ID_LO;
      A_PAGE:  rd_mux[B_PGRX] = page_rx;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_stb) rd_data <= rd_mux;
  end

  a_r13_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));
  a_r5_ext: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (rd_data[B_EXT] && rd_data[15:3] == '0));
  a_r12_unimpl: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && reg_addr != A_CTRL && reg_addr != A_STAT && reg_addr != A_IDHI
     && reg_addr != A_IDLO && reg_addr != A_PAGE) |=> (rd_data == '0));
  a_r9_pulse_src: assert property (@(posedge clk) disable iff (rst)
    an_restart_o |-> $past(ctrl_wr));
endmodule

// File: tb/phy_mgmt_regs_test.sv
module phy_mgmt_regs_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] reg_addr = '0;
  logic rd_stb = 1'b0, wr_stb = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic link_pass = 1'b0, jabber_evt = 1'b0, page_rx_evt = 1'b0, link_lost = 1'b0;
  logic soft_rst_o, an_restart_o, power_down_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  phy_mgmt_regs uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data), .link_pass(link_pass),
    .jabber_evt(jabber_evt), .page_rx_evt(page_rx_evt), .link_lost(link_lost),
    .soft_rst_o(soft_rst_o), .an_restart_o(an_restart_o), .power_down_o(power_down_o)
  );

  // {addr, write data, expected read-back}, link down, no events pending
  localparam logic [36:0] VEC [10] = '{
    {5'd2,  16'hFFFF, 16'h0000},   // R6
    {5'd3,  16'h0000, 16'h8201},   // R6
    {5'd0,  16'h0800, 16'h0800},   // R10
    {5'd0,  16'h0000, 16'h0000},   // R10
    {5'd0,  16'h14FF, 16'h0000},   // R10 other bits read 0
    {5'd1,  16'hFFFF, 16'h0001},   // R5
    {5'd6,  16'hFFFF, 16'h0000},   // R11
    {5'd5,  16'hFFFF, 16'h0000},   // R12
    {5'd17, 16'hABCD, 16'h0000},   // R12
    {5'd31, 16'hFFFF, 16'h0000}    // R12
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 rd_data", rd_data, 16'h0000);
    check("R1 soft_rst_o", {15'd0, soft_rst_o}, 16'h0000);
    check("R1 an_restart_o", {15'd0, an_restart_o}, 16'h0000);
    check("R1 power_down_o", {15'd0, power_down_o}, 16'h0000);

    // table walk
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][36:32], VEC[i][31:16]);
      rd(VEC[i][36:32], v);
      check($sformatf("R5/R6/R10/R12 vector %0d", i), v, VEC[i][15:0]);
    end

    // R10 power-down output
    wr(5'd0, 16'h0800);
    check("R10 power_down_o set", {15'd0, power_down_o}, 16'h0001);
    wr(5'd0, 16'h0000);
    check("R10 power_down_o clear", {15'd0, power_down_o}, 16'h0000);

    // R2 / R3 link latch
    link_pass = 1'b1; idle(2);
    rd(5'd1, v); check("R2 link up", v, 16'h0005);
    @(negedge clk) link_pass = 1'b0;
    @(negedge clk) link_pass = 1'b1;
    idle(3);
    rd(5'd1, v); check("R2 latched low", v, 16'h0001);
    rd(5'd1, v); check("R3 recovered after read", v, 16'h0005);
    // drop in the same cycle as the read
    @(negedge clk);
    reg_addr = 5'd1; rd_stb = 1'b1; link_pass = 1'b0;
    @(negedge clk);
    rd_stb = 1'b0; link_pass = 1'b1;
    check("R2 pre-update value on drop cycle", rd_data, 16'h0005);
    idle(2);
    rd(5'd1, v); check("R2 drop not lost", v, 16'h0001);
    rd(5'd1, v); check("R3 back up", v, 16'h0005);
    // read while link still down, recovery later
    @(negedge clk) link_pass = 1'b0;
    idle(2);
    rd(5'd1, v); check("R2 down read", v, 16'h0001);
    @(negedge clk) link_pass = 1'b1;
    idle(2);
    rd(5'd1, v); check("R3 later recovery", v, 16'h0005);
    @(negedge clk) link_pass = 1'b0;
    idle(1);
    rd(5'd1, v);

    // R4 jabber
    @(negedge clk) jabber_evt = 1'b1;
    @(negedge clk) jabber_evt = 1'b0;
    rd(5'd1, v); check("R4 jabber set", v, 16'h0003);
    rd(5'd1, v); check("R4 cleared on read", v, 16'h0001);
    @(negedge clk);
    reg_addr = 5'd1; rd_stb = 1'b1; jabber_evt = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0; jabber_evt = 1'b0;
    check("R4 same-cycle read pre value", rd_data, 16'h0001);
    rd(5'd1, v); check("R4 same-cycle event kept", v, 16'h0003);
    rd(5'd1, v); check("R4 cleared again", v, 16'h0001);

    // R11 page flag
    @(negedge clk) page_rx_evt = 1'b1;
    @(negedge clk) page_rx_evt = 1'b0;
    rd(5'd6, v); check("R11 page set", v, 16'h0002);
    rd(5'd6, v); check("R11 not cleared by read", v, 16'h0002);
    @(negedge clk) link_lost = 1'b1;
    @(negedge clk) link_lost = 1'b0;
    rd(5'd6, v); check("R11 cleared by link_lost", v, 16'h0000);
    @(negedge clk) begin page_rx_evt = 1'b1; link_lost = 1'b1; end
    @(negedge clk) begin page_rx_evt = 1'b0; link_lost = 1'b0; end
    rd(5'd6, v); check("R11 link_lost wins", v, 16'h0000);

    // R9 restart pulse
    wr(5'd0, 16'h0200);
    check("R9 pulse high", {15'd0, an_restart_o}, 16'h0001);
    @(negedge clk);
    check("R9 pulse one cycle", {15'd0, an_restart_o}, 16'h0000);
    rd(5'd0, v); check("R9 bit reads 0", v, 16'h0000);

    // R13 hold
    rd(5'd3, v);
    reg_addr = 5'd2;
    idle(4);
    check("R13 hold", rd_data, 16'h8201);

    // R7 write 0 does nothing, then pulse length
    wr(5'd0, 16'h0000);
    check("R7 zero write no reset", {15'd0, soft_rst_o}, 16'h0000);
    wr(5'd0, 16'h8000);
    n = 0;
    while (soft_rst_o && n < 1000) begin n++; @(negedge clk); end
    check("R7 pulse length", 16'(n), 16'd50);

    // R8 holds during reset
    wr(5'd0, 16'h0800);
    @(negedge clk) jabber_evt = 1'b1;
    @(negedge clk) begin jabber_evt = 1'b0; page_rx_evt = 1'b1; end
    @(negedge clk) page_rx_evt = 1'b0;
    wr(5'd0, 16'h8000);
    check("R8 power_down forced 0", {15'd0, power_down_o}, 16'h0000);
    rd(5'd0, v); check("R7 bit15 reads 1 while busy", v, 16'h8000);
    wr(5'd0, 16'h0800);
    check("R8 write ignored", {15'd0, power_down_o}, 16'h0000);
    n = 0;
    while (soft_rst_o && n < 1000) begin n++; @(negedge clk); end
    rd(5'd0, v); check("R7 bit15 reads 0 after", v, 16'h0000);
    rd(5'd1, v); check("R8 jabber cleared", v, 16'h0001);
    rd(5'd6, v); check("R8 page cleared", v, 16'h0000);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule